// File: doc/BRIEF.md
# Zero-Operand Stack Execute Unit

This block is a small stack-based execute unit. It runs a fixed program from an internal instruction ROM, which is set by a parameter. Arithmetic instructions name no operands. They always consume the two topmost entries of an internal operand stack and push one result back. The only instructions that reach the word-addressed data RAM are LOAD and STORE, and each names exactly one address. PUSH places an immediate value on the stack. An expression such as z = x + y is therefore written in postfix order: LOAD x, LOAD y, ADD, STORE z.

A pulse on `start` clears the stack and the flags and begins execution at ROM word 0. The unit then executes one instruction per clock until it reaches HALT or a fault. A fault is a stack overflow, a stack underflow or an undefined opcode. A fault raises `errFlag`, and both a fault and HALT raise `halted`. The top of the stack is held in a register and is visible at all times on `stackTop`. A test program checks its results by loading them onto the stack before it halts.

Top module: `stack_machine`

## Requirements
- R1: After reset, `halted`, `errFlag` and `stackTop` are 0, the stack is empty, the data RAM holds zeros, and nothing executes until `start` is seen high.
- R2: `start`, sampled while the unit is idle or halted, empties the stack, clears `errFlag` and `halted`, and sets the fetch address to ROM word 0. `start` is ignored while running. From then on the unit executes one instruction per clock, so `halted` rises exactly N cycles after the start edge when the N-th instruction ends the run.
- R3: An instruction word is 12 bits wide. Bits 11:8 hold the opcode and bits 7:0 hold an address or immediate. The opcodes are HALT=0, PUSH=1, POP=2, LOAD=3, STORE=4, ADD=5, SUB=6, MULT=7. Any other opcode sets `errFlag` and halts.
- R4: PUSH places its 8-bit field, zero-extended to 16 bits, on the top of the stack. POP discards the top entry. `stackTop` shows the new top entry, or 0 when the stack is empty.
- R5: LOAD pushes the RAM word at its address. STORE pops the top entry and writes it to its address. The RAM has 16 words, and an address selects word (address mod 16).
- R6: ADD and MULT replace the two top entries with their sum or product, truncated to 16 bits. SUB replaces them with (second-from-top minus top) mod 2^16.
- R7: The ADD, SUB, MULT, POP and HALT instructions ignore the 8-bit field.
- R8: The stack holds 8 entries. A push (PUSH or LOAD) onto a full stack sets `errFlag` and halts, and leaves the stack unchanged.
- R9: POP or STORE on an empty stack, or a binary operation with fewer than two entries, sets `errFlag` and halts, and leaves the stack unchanged.
- R10: After HALT the unit fetches nothing more. `halted`, `errFlag` and `stackTop` hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run from ROM word 0 |
| halted | output | 1 | Run has ended by HALT or by fault |
| errFlag | output | 1 | Run ended by overflow, underflow or undefined opcode |
| stackTop | output | 16 | Current top-of-stack entry, 0 when empty |

## Verification
Fifteen short programs each run on their own instance. They are compared on final top of stack, error flag and the exact number of cycles until halt. Together they separate operand order (SUB on 9,3 versus on 1,2, where the second wraps), truncation (MULT of 255 by 255, and a sum that overflows), memory round trips including address aliasing, and the field being ignored by zero-operand instructions. The fault programs separate the exactly-full stack from the one-too-many push, and POP, STORE and a binary operation on too few entries from each other. Directed steps then cover the reset state, idling without a start pulse, stability after halt, and a restart that clears the error flag.

// File: rtl/stack_machine_pkg.sv
package stack_machine_pkg;

  typedef enum logic [3:0] {
    OP_HALT  = 4'd0,
    OP_PUSH  = 4'd1,
    OP_POP   = 4'd2,
    OP_LOAD  = 4'd3,
    OP_STORE = 4'd4,
    OP_ADD   = 4'd5,
    OP_SUB   = 4'd6,
    OP_MUL   = 4'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2
  } aluOp_e;

  // Strobes from control to datapath, valid for one cycle each.
  typedef struct packed {
    logic       clear;
    logic       pushImm;
    logic       pushMem;
    logic       pop;
    logic       store;
    logic       arith;
    aluOp_e     aluOp;
    logic [7:0] field;
  } strobe_t;

endpackage

// File: rtl/smc_control.sv
module smc_control
  import stack_machine_pkg::*;
#(
  parameter int ROM_DEPTH = 16,
  parameter int DEPTH     = 8,
  parameter int CNT_W     = 4,
  parameter logic [ROM_DEPTH*12-1:0] PROGRAM = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] depthCnt,
  output strobe_t          stb,
  output logic             halted,
  output logic             errFlag
);

  localparam int PC_W = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e            state;
  logic [PC_W-1:0]   pc;
  logic [11:0]       instr;
  logic              fault;
  logic              stop;

  always_comb begin
    instr = PROGRAM[32'(pc)*12 +: 12];
    stb   = '0;
    stb.field = instr[7:0];
    fault = 1'b0;
    stop  = 1'b0;
    if (state != ST_RUN) begin
      stb.clear = start;
    end else begin
      case (instr[11:8])
        OP_HALT:  stop = 1'b1;
        OP_PUSH:  if (depthCnt == CNT_W'(DEPTH)) fault = 1'b1; else stb.pushImm = 1'b1;
        OP_LOAD:  if (depthCnt == CNT_W'(DEPTH)) fault = 1'b1; else stb.pushMem = 1'b1;
        OP_POP:   if (depthCnt == '0) fault = 1'b1; else stb.pop = 1'b1;
        OP_STORE: if (depthCnt == '0) fault = 1'b1; else stb.store = 1'b1;
        OP_ADD, OP_SUB, OP_MUL: begin
          if (depthCnt < CNT_W'(2)) fault = 1'b1;
          else begin
            stb.arith = 1'b1;
            stb.aluOp = (instr[11:8] == OP_ADD) ? ALU_ADD :
                        (instr[11:8] == OP_SUB) ? ALU_SUB : ALU_MUL;
          end
        end
        default:  fault = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pc      <= '0;
      errFlag <= 1'b0;
    end else if (state != ST_RUN) begin
      if (start) begin
        state   <= ST_RUN;
        pc      <= '0;
        errFlag <= 1'b0;
      end
    end else if (fault) begin
      state   <= ST_DONE;
      errFlag <= 1'b1;
    end else if (stop) begin
      state <= ST_DONE;
    end else begin
      pc <= pc + 1'b1;
    end
  end

  assign halted = (state == ST_DONE);

endmodule

// File: rtl/smc_datapath.sv
module smc_datapath
  import stack_machine_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int DEPTH     = 8,
  parameter int RAM_DEPTH = 16,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  output logic [WIDTH-1:0] stackTop,
  output logic [CNT_W-1:0] depthCnt
);

  localparam int RAM_AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
  localparam int IDX_W  = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  // Entries below the top: lower[0] is the bottom of the stack.
  logic [WIDTH-1:0] lower [DEPTH-1];
  logic [WIDTH-1:0] ram   [RAM_DEPTH];

  logic [IDX_W-1:0]  pushIdx, belowIdx;
  logic [RAM_AW-1:0] addr;
  logic [WIDTH-1:0]  below, pushVal, aluRes;
  logic              pushAny;

  always_comb begin
    pushIdx  = IDX_W'(depthCnt - 1'b1);
    belowIdx = IDX_W'(depthCnt - CNT_W'(2));
    below    = (depthCnt >= CNT_W'(2)) ? lower[belowIdx] : '0;
    addr     = stb.field[RAM_AW-1:0];
    pushAny  = stb.pushImm | stb.pushMem;
    pushVal  = stb.pushImm ? WIDTH'(stb.field) : ram[addr];
    case (stb.aluOp)
      ALU_ADD: aluRes = below + stackTop;
      ALU_SUB: aluRes = below - stackTop;
      default: aluRes = below * stackTop;
    endcase
  end

  always_ff @(posedge clk) begin
    if (pushAny && depthCnt != '0) lower[pushIdx] <= stackTop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depthCnt <= '0;
      stackTop <= '0;
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
    end else begin
      if (stb.clear) begin
        depthCnt <= '0;
        stackTop <= '0;
      end
      if (pushAny) begin
        stackTop <= pushVal;
        depthCnt <= depthCnt + 1'b1;
      end
      if (stb.pop || stb.store) begin
        stackTop <= below;
        depthCnt <= depthCnt - 1'b1;
      end
      if (stb.store) ram[addr] <= stackTop;
      if (stb.arith) begin
        stackTop <= aluRes;
        depthCnt <= depthCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/stack_machine.sv
module stack_machine
  import stack_machine_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int DEPTH     = 8,
  parameter int ROM_DEPTH = 16,
  parameter int RAM_DEPTH = 16,
  parameter logic [ROM_DEPTH*12-1:0] PROGRAM = (ROM_DEPTH*12)'({
    12'h000, 12'h302, 12'h402, 12'h500, 12'h301,
    12'h300, 12'h401, 12'h107, 12'h400, 12'h105})
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             halted,
  output logic             errFlag,
  output logic [WIDTH-1:0] stackTop
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  strobe_t          stb;
  logic [CNT_W-1:0] depthCnt;

  smc_control #(
    .ROM_DEPTH(ROM_DEPTH), .DEPTH(DEPTH), .CNT_W(CNT_W), .PROGRAM(PROGRAM)
  ) uCtrl (
    .clk(clk), .rst(rst), .start(start), .depthCnt(depthCnt),
    .stb(stb), .halted(halted), .errFlag(errFlag)
  );

  smc_datapath #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .RAM_DEPTH(RAM_DEPTH), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rst(rst), .stb(stb), .stackTop(stackTop), .depthCnt(depthCnt)
  );

endmodule

// File: rtl/stack_machine_chk.sv
module stack_machine_chk
  import stack_machine_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             halted,
  input logic             errFlag,
  input logic [WIDTH-1:0] stackTop,
  input logic [CNT_W-1:0] depthCnt,
  input strobe_t          stb
);

  a_r8_error_halts: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> halted);

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depthCnt <= CNT_W'(DEPTH));

  a_r3_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.pushImm, stb.pushMem, stb.pop, stb.store, stb.arith}));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    (start && halted) |=> (!errFlag && !halted && depthCnt == '0));

  a_r4_push_grows: assert property (@(posedge clk) disable iff (rst)
    (stb.pushImm || stb.pushMem) |=> depthCnt == $past(depthCnt) + 1'b1);

  a_r6_arith_shrinks: assert property (@(posedge clk) disable iff (rst)
    stb.arith |=> depthCnt == $past(depthCnt) - 1'b1);

  a_r10_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> (halted && $stable(stackTop) && $stable(errFlag)));

endmodule

bind stack_machine stack_machine_chk #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .CNT_W(CNT_W)
) uChk (
  .clk(clk), .rst(rst), .start(start), .halted(halted), .errFlag(errFlag),
  .stackTop(stackTop), .depthCnt(depthCnt), .stb(stb)
);

// File: tb/sim_stack_machine.sv
module sim_stack_machine;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 15;
  localparam int PW = 16 * 12;

  // Opcodes: HALT 0, PUSH 1, POP 2, LOAD 3, STORE 4, ADD 5, SUB 6, MULT 7.
  // Words listed last-first; unlisted words are 0 (HALT).
  localparam logic [PW-1:0] PROG [NC] = '{
    PW'({12'h000, 12'h302, 12'h402, 12'h500, 12'h301, 12'h300, 12'h401, 12'h107, 12'h400, 12'h105}),
    PW'({12'h000, 12'h600, 12'h103, 12'h109}),
    PW'({12'h000, 12'h700, 12'h1FF, 12'h1FF}),
    PW'({12'h000, 12'h109, 12'h108, 12'h107, 12'h106, 12'h105, 12'h104, 12'h103, 12'h102, 12'h101}),
    PW'({12'h000, 12'h200}),
    PW'({12'h000, 12'h500, 12'h104}),
    PW'({12'h000, 12'h200, 12'h10B, 12'h10A}),
    PW'({12'h000, 12'hF00, 12'h103}),
    PW'({12'h0AB, 12'h5FF, 12'h103, 12'h102}),
    PW'({12'h000, 12'h600, 12'h102, 12'h101}),
    PW'({12'h000, 12'h500, 12'h700, 12'h1FF, 12'h1FF, 12'h700, 12'h1FF, 12'h1FF}),
    PW'({12'h000, 12'h401}),
    PW'({12'h000, 12'h108, 12'h107, 12'h106, 12'h105, 12'h104, 12'h103, 12'h102, 12'h101}),
    PW'({12'h000, 12'h200, 12'h107}),
    PW'({12'h000, 12'h301, 12'h411, 12'h10B})
  };
  localparam int          EXP_CYC [NC] = '{10, 4, 4, 9, 1, 2, 4, 2, 4, 4, 8, 1, 9, 3, 4};
  localparam logic [15:0] EXP_TOP [NC] = '{16'd12, 16'd6, 16'hFE01, 16'd8, 16'd0, 16'd4, 16'd10,
                                           16'd3, 16'd5, 16'hFFFF, 16'hFC02, 16'd0, 16'd8, 16'd0, 16'hB};
  localparam logic        EXP_ERR [NC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
                                           1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        halted, errFlag;
  logic [15:0] stackTop;
  logic [NC-1:0] haltV, errV;
  logic [15:0]   topV [NC];

  stack_machine u0 (
    .clk(clk), .rst(rst), .start(start),
    .halted(halted), .errFlag(errFlag), .stackTop(stackTop)
  );

  for (genvar g = 0; g < NC; g++) begin : gCase
    stack_machine #(.PROGRAM(PROG[g])) uCase (
      .clk(clk), .rst(rst), .start(start),
      .halted(haltV[g]), .errFlag(errV[g]), .stackTop(topV[g])
    );
  end

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string caseReq [NC];
  int    cyc [NC];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    caseReq = '{"R5 add via memory", "R6 sub order", "R6 mult truncation", "R8 overflow",
                "R9 pop on empty", "R9 add with one entry", "R4 pop", "R3 undefined opcode",
                "R7 field ignored", "R6 sub wraps", "R6 sum truncation", "R9 store on empty",
                "R8 exactly full", "R4 pop to empty", "R5 address aliasing"};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state and idle without start
    check(!halted && !errFlag && stackTop == 16'd0, "R1", "reset state",
          {29'd0, halted, errFlag, |stackTop}, 32'd0);
    repeat (5) @(negedge clk);
    check(!halted && haltV == '0 && stackTop == 16'd0, "R1", "idle without start",
          32'(haltV), 32'd0);

    // R2: cycle-exact run for every program
    pulseStart();
    for (int i = 0; i < NC; i++) cyc[i] = 0;
    for (int t = 1; t <= 40; t++) begin
      @(negedge clk);
      for (int i = 0; i < NC; i++) if (haltV[i] && cyc[i] == 0) cyc[i] = t;
    end
    for (int i = 0; i < NC; i++) begin
      check(cyc[i] == EXP_CYC[i], {"R2 ", caseReq[i]}, "cycles to halt", cyc[i], EXP_CYC[i]);
      check(topV[i] == EXP_TOP[i], caseReq[i], "top of stack", topV[i], EXP_TOP[i]);
      check(errV[i] == EXP_ERR[i], caseReq[i], "error flag", errV[i], EXP_ERR[i]);
    end
    check(halted && !errFlag && stackTop == 16'd12, "R5", "default program result", stackTop, 16'd12);

    // R10: state held after halt
    repeat (4) @(negedge clk);
    check(halted && stackTop == 16'd12, "R10", "top held after halt", stackTop, 16'd12);
    check(haltV[3] && errV[3] && topV[3] == 16'd8, "R10", "fault state held", topV[3], 16'd8);

    // R2: restart clears flags and stack
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!errV[3] && !haltV[3] && topV[3] == 16'd0, "R2", "restart clears error",
          {30'd0, errV[3], haltV[3]}, 32'd0);
    check(!halted && stackTop == 16'd0, "R2", "restart empties stack", stackTop, 16'd0);
    repeat (20) @(negedge clk);
    check(halted && stackTop == 16'd12, "R2", "second run result", stackTop, 16'd12);
    check(errV[3] && topV[3] == 16'd8, "R8", "overflow again on rerun", topV[3], 16'd8);
    finish();
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

endmodule